// File: doc/BRIEF.md
# PC Sampling Profiling Register Unit

This block is a small APB register slave that lets software take a snapshot of where a processor is running. The processor keeps running while this happens. The core side drives the block with the following live signals:

- the program counter
- the context identifier
- the virtual machine identifier
- the security state
- the exception-level flags and the register-width flag
- a power-up flag and a double-lock flag
- a halted flag and a profiling-prohibit flag

Reading the low PC sample register returns the live low half of the PC. On the same clock edge, the block copies the context identifier, the virtual-context word and the upper PC half into shadow registers. Later reads of those shadows therefore belong to one coherent sample.

Access to the sample registers is gated. The core domain must be powered, it must not be double-locked, and software must have opened the OS lock by writing zero to it. A status register reports power and double-lock and can always be read. Two ID registers report which sample registers exist and how the sampled PC is offset. They can also always be read.

Two small state machines run the block:

- **APB phase machine.** Its states are `AP_IDLE`, `AP_SETUP` and `AP_ACCESS`.
  - `AP_IDLE` goes to `AP_SETUP` when `psel` is high.
  - `AP_SETUP` goes to `AP_ACCESS` when `penable` rises; a transfer takes effect only in this cycle.
  - `AP_ACCESS` goes to `AP_SETUP` on a back-to-back select, and otherwise to `AP_IDLE`.
- **Lock machine.** Its states are `LK_LOCKED`, which is the reset state, and `LK_OPEN`.
  - An unlock write goes from `LK_LOCKED` to `LK_OPEN`.
  - A lock write or a loss of power goes from `LK_OPEN` to `LK_LOCKED`.

Top module: `pcs_profiler`

## Requirements
- R1: The slave has zero wait states: `pready` is always 1. Outside an access phase (psel and penable both high), `pslverr` is 0 and `prdata` is 0.
- R2: The status register at offset 0x314 can be read at any time without error. Bit 0 is the core power-up flag, bit 6 is the double-lock flag, and all other bits are 0.
- R3: Both ID registers can be read at any time without error.
  - Offset 0xFC8 bits [3:0] give the sampling implementation: 0 means none, 2 means PC and context only, 3 means full.
  - Offset 0xFC4 bits [3:0] give the PC offset mode: 0 means the sampled PC includes an instruction-set offset, 1 means no offset.
- R4: The OS lock resets to locked.
  - A write of zero to offset 0x300 opens it; a write of any nonzero value closes it.
  - Such writes are ignored while the core is powered down or double-locked.
  - Loss of core power closes the lock.
  - Reads of 0x300 return 0.
- R5: Reads of the sample registers (0x0A0, 0x0A4, 0x0A8, 0x0AC) return 0 with `pslverr`=1, and capture nothing, in any of these cases: the core is powered down (status bit 0 clear), the core is double-locked (status bit 6 set), or the OS lock is closed.
- R6: A permitted read of 0x0A0 returns the live PC bits [31:0]. On the same edge it loads these shadows from the core values of that cycle:
  - the context-ID shadow (0x0A4);
  - the virtual-context shadow (0x0A8);
  - the PC-high shadow (0x0AC), which takes PC bits [63:32].
- R7: If the core is halted or profiling is prohibited, a permitted read of 0x0A0 returns 0xFFFFFFFF and leaves all shadows unchanged.
- R8: Shadow registers reset to 0. A read of a shadow register returns the value of the last capture, never the live core value.
- R9: The virtual-context shadow layout is:
  - bit 31: non-secure
  - bit 30: EL2
  - bit 29: EL3
  - bit 28: 64-bit state
  - bits [7:0]: VMID
  - all other bits: 0
- R10: Reads of undefined offsets return 0 without error. Writes to read-only registers change nothing.
- R11: With the implementation code set to 2, the virtual-context register reads 0 and is never loaded. With the code set to 0, all sample registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Access refused |
| core_pc | input | 64 | Live program counter |
| core_ctxid | input | 32 | Live context identifier |
| core_vmid | input | 8 | Live VMID |
| core_ns | input | 1 | Non-secure state |
| core_el2 | input | 1 | Running at EL2 |
| core_el3 | input | 1 | Running at EL3 |
| core_aa64 | input | 1 | 64-bit register state |
| core_pwr_up | input | 1 | Core domain powered |
| core_dbl_lock | input | 1 | Core double-locked |
| core_halted | input | 1 | Core in debug halt |
| core_prof_off | input | 1 | Sample profiling prohibited |

## Verification
A wrong lock state shows up on the very next sample read, as an unexpected `pslverr` or a missing one. A phase machine that is out of step either drops a capture or takes one in the wrong cycle. In that case a shadow read one transfer later returns a stale value or the live value. Shadows that follow the core instead of holding are exposed by changing the core inputs between a capture and the shadow read. A capture taken while halted is exposed the same way.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_PCLO   = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_CTX    = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_VCTX   = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFS_PCHI   = 12'h0AC;
    localparam logic [ADDR_W-1:0] OFS_OSLOCK = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h314;
    localparam logic [ADDR_W-1:0] OFS_DEVID1 = 12'hFC4;
    localparam logic [ADDR_W-1:0] OFS_DEVID  = 12'hFC8;

    localparam int STAT_PWR_BIT = 0;
    localparam int STAT_DLK_BIT = 6;

    typedef enum logic [1:0] {AP_IDLE, AP_SETUP, AP_ACCESS} apb_state_e;
    typedef enum logic {LK_LOCKED, LK_OPEN} lock_state_e;

    function automatic logic in_core_domain(input logic [ADDR_W-1:0] a);
        return (a == OFS_PCLO) || (a == OFS_CTX) || (a == OFS_VCTX) || (a == OFS_PCHI);
    endfunction
endpackage

// File: rtl/pcs_apb_phase.sv
module pcs_apb_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic fire
);
    import pcs_pkg::*;

    apb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            AP_IDLE:   if (psel) state_d = AP_SETUP;
            AP_SETUP: begin
                if (!psel) begin
                    state_d = AP_IDLE;
                end else if (penable) begin
                    fire    = 1'b1;
                    state_d = AP_ACCESS;
                end
            end
            AP_ACCESS: state_d = (psel && !penable) ? AP_SETUP : AP_IDLE;
        endcase
    end
endmodule

// File: rtl/pcs_oslock.sv
module pcs_oslock (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic wr_en,
    input  logic wr_lock,
    output logic is_open
);
    import pcs_pkg::*;

    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (pwr_up && wr_en && !wr_lock) state_d = LK_OPEN;
            LK_OPEN:   if (!pwr_up || (wr_en && wr_lock)) state_d = LK_LOCKED;
        endcase
    end

    assign is_open = (state_q == LK_OPEN);
endmodule

// File: rtl/pcs_shadow.sv
module pcs_shadow #(
    parameter int PC_W      = 64,
    parameter int CTX_W     = 32,
    parameter int VMID_W    = 8,
    parameter bit HAS_VCTX  = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic [PC_W-1:0]            core_pc,
    input  logic [CTX_W-1:0]           core_ctxid,
    input  logic [VMID_W-1:0]          core_vmid,
    input  logic                       core_ns,
    input  logic                       core_el2,
    input  logic                       core_el3,
    input  logic                       core_aa64,
    output logic [pcs_pkg::DATA_W-1:0] sh_ctx,
    output logic [pcs_pkg::DATA_W-1:0] sh_vctx,
    output logic [pcs_pkg::DATA_W-1:0] sh_pchi
);
    import pcs_pkg::*;
    localparam int VPAD_W = DATA_W - 4 - VMID_W;
    localparam int HI_W   = PC_W - DATA_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ctx  <= '0;
            sh_pchi <= '0;
        end else if (capture) begin
            sh_ctx  <= DATA_W'(core_ctxid);
            sh_pchi <= DATA_W'(core_pc[PC_W-1 -: HI_W]);
        end
    end

    generate
        if (HAS_VCTX) begin : g_vctx
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       sh_vctx <= '0;
                else if (capture) sh_vctx <= {core_ns, core_el2, core_el3, core_aa64,
                                               {VPAD_W{1'b0}}, core_vmid};
            end
        end else begin : g_no_vctx
            assign sh_vctx = '0;
        end
    endgenerate
endmodule

// File: rtl/pcs_profiler.sv
module pcs_profiler #(
    parameter int PC_W        = 64,
    parameter int CTX_W       = 32,
    parameter int VMID_W      = 8,
    parameter int IMPL_MODE   = 3,
    parameter int PC_OFS_MODE = 1
) (
    input  logic                       pclk,
    input  logic                       presetn,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [pcs_pkg::ADDR_W-1:0] paddr,
    input  logic [pcs_pkg::DATA_W-1:0] pwdata,
    output logic [pcs_pkg::DATA_W-1:0] prdata,
    output logic                       pready,
    output logic                       pslverr,
    input  logic [PC_W-1:0]            core_pc,
    input  logic [CTX_W-1:0]           core_ctxid,
    input  logic [VMID_W-1:0]          core_vmid,
    input  logic                       core_ns,
    input  logic                       core_el2,
    input  logic                       core_el3,
    input  logic                       core_aa64,
    input  logic                       core_pwr_up,
    input  logic                       core_dbl_lock,
    input  logic                       core_halted,
    input  logic                       core_prof_off
);
    import pcs_pkg::*;

    localparam bit         HAS_PC    = (IMPL_MODE != 0);
    localparam bit         HAS_VCTX  = (IMPL_MODE == 3);
    localparam logic [3:0] IMPL_CODE = 4'(IMPL_MODE);
    localparam logic [3:0] OFS_CODE  = 4'(PC_OFS_MODE);

    logic              fire, os_open, permit, blocked, capture, lk_wr;
    logic [DATA_W-1:0] sh_ctx, sh_vctx, sh_pchi;

    pcs_apb_phase u_phase (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable), .fire(fire)
    );

    pcs_oslock u_lock (
        .clk(pclk), .rst_n(presetn), .pwr_up(core_pwr_up),
        .wr_en(lk_wr), .wr_lock(|pwdata), .is_open(os_open)
    );

    pcs_shadow #(.PC_W(PC_W), .CTX_W(CTX_W), .VMID_W(VMID_W), .HAS_VCTX(HAS_VCTX)) u_shadow (
        .clk(pclk), .rst_n(presetn), .capture(capture),
        .core_pc(core_pc), .core_ctxid(core_ctxid), .core_vmid(core_vmid),
        .core_ns(core_ns), .core_el2(core_el2), .core_el3(core_el3), .core_aa64(core_aa64),
        .sh_ctx(sh_ctx), .sh_vctx(sh_vctx), .sh_pchi(sh_pchi)
    );

    assign permit  = core_pwr_up && !core_dbl_lock && os_open;
    assign blocked = core_halted || core_prof_off;
    assign pready  = 1'b1;

    always_comb begin
        prdata  = '0;
        pslverr = 1'b0;
        capture = 1'b0;
        lk_wr   = 1'b0;
        if (fire) begin
            if (pwrite) begin
                lk_wr = (paddr == OFS_OSLOCK) && core_pwr_up && !core_dbl_lock;
            end else if (in_core_domain(paddr)) begin
                if (!permit) begin
                    pslverr = 1'b1;
                end else if (HAS_PC) begin
                    unique case (paddr)
                        OFS_PCLO: begin
                            prdata  = blocked ? '1 : core_pc[DATA_W-1:0];
                            capture = !blocked;
                        end
                        OFS_CTX:  prdata = sh_ctx;
                        OFS_VCTX: prdata = sh_vctx;
                        default:  prdata = sh_pchi;
                    endcase
                end
            end else begin
                case (paddr)
                    OFS_STATUS: begin
                        prdata[STAT_PWR_BIT] = core_pwr_up;
                        prdata[STAT_DLK_BIT] = core_dbl_lock;
                    end
                    OFS_DEVID:  prdata[3:0] = IMPL_CODE;
                    OFS_DEVID1: prdata[3:0] = OFS_CODE;
                    default:    prdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pcs_profiler_chk.sv
module pcs_profiler_chk #(
    parameter int CTX_W     = 32,
    parameter int IMPL_MODE = 3
) (
    input logic                       pclk,
    input logic                       presetn,
    input logic                       psel,
    input logic                       penable,
    input logic                       pwrite,
    input logic [pcs_pkg::ADDR_W-1:0] paddr,
    input logic [pcs_pkg::DATA_W-1:0] prdata,
    input logic                       pslverr,
    input logic [CTX_W-1:0]           core_ctxid,
    input logic                       core_pwr_up,
    input logic                       core_dbl_lock,
    input logic                       core_halted,
    input logic                       core_prof_off,
    input logic                       os_open,
    input logic [pcs_pkg::DATA_W-1:0] sh_ctx
);
    import pcs_pkg::*;

    logic rd_now, pc_rd, ok;
    assign rd_now = psel && penable && !pwrite;
    assign pc_rd  = rd_now && (paddr == OFS_PCLO);
    assign ok     = core_pwr_up && !core_dbl_lock && os_open;

    a_r1_quiet_idle: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable) |-> (!pslverr && prdata == '0));

    a_r4_power_loss_relocks: assert property (@(posedge pclk) disable iff (!presetn)
        !core_pwr_up |=> !os_open);

    a_r5_gated_read_errors: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_now && $past(psel && !penable) && in_core_domain(paddr) && !ok)
        |-> (pslverr && prdata == '0));

    a_r6_capture_ctx: assert property (@(posedge pclk) disable iff (!presetn)
        (IMPL_MODE != 0 && pc_rd && $past(psel && !penable) && ok && !core_halted && !core_prof_off)
        |=> (sh_ctx == DATA_W'($past(core_ctxid))));

    a_r7_blocked_all_ones: assert property (@(posedge pclk) disable iff (!presetn)
        (IMPL_MODE != 0 && pc_rd && $past(psel && !penable) && ok && (core_halted || core_prof_off))
        |-> (prdata == '1));

    a_r8_shadow_holds: assert property (@(posedge pclk) disable iff (!presetn)
        !pc_rd |=> $stable(sh_ctx));
endmodule

bind pcs_profiler pcs_profiler_chk #(.CTX_W(CTX_W), .IMPL_MODE(IMPL_MODE)) u_chk (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .prdata(prdata), .pslverr(pslverr), .core_ctxid(core_ctxid),
    .core_pwr_up(core_pwr_up), .core_dbl_lock(core_dbl_lock), .core_halted(core_halted),
    .core_prof_off(core_prof_off), .os_open(os_open), .sh_ctx(sh_ctx)
);

// File: tb/tb_pcs_profiler.sv
`timescale 1ns/1ps
module tb_pcs_profiler;
    logic        pclk = 1'b0, presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, prdata_l;
    logic        pready, pready_l, pslverr, pslverr_l;
    logic [63:0] core_pc = '0;
    logic [31:0] core_ctxid = '0;
    logic [7:0]  core_vmid = '0;
    logic core_ns = 0, core_el2 = 0, core_el3 = 0, core_aa64 = 0;
    logic core_pwr_up = 1, core_dbl_lock = 0, core_halted = 0, core_prof_off = 0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 pclk = ~pclk;

    pcs_profiler dut (.pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .core_pc, .core_ctxid, .core_vmid, .core_ns, .core_el2, .core_el3, .core_aa64,
        .core_pwr_up, .core_dbl_lock, .core_halted, .core_prof_off);

    pcs_profiler #(.IMPL_MODE(2), .PC_OFS_MODE(0)) dut_lite (.pclk, .presetn, .psel, .penable,
        .pwrite, .paddr, .pwdata, .prdata(prdata_l), .pready(pready_l), .pslverr(pslverr_l),
        .core_pc, .core_ctxid, .core_vmid, .core_ns, .core_el2, .core_el3, .core_aa64,
        .core_pwr_up, .core_dbl_lock, .core_halted, .core_prof_off);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic e,
                      output logic [31:0] dl);
        @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk); penable = 1; #1;
        d = prdata; e = pslverr; dl = prdata_l;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = v; penable = 0;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    logic [31:0] d, dl; logic e;

    task automatic t_reset_idle();
        #1;
        check("R1 pready", {31'b0, pready}, 32'h1);
        check("R1 idle slverr", {31'b0, pslverr}, 32'h0);
        check("R1 idle prdata", prdata, 32'h0);
        rd(12'h314, d, e, dl);
        check("R2 status powered", d, 32'h1);
        check("R2 status no error", {31'b0, e}, 32'h0);
        rd(12'h0A0, d, e, dl);
        check("R4 reset locked err", {31'b0, e}, 32'h1);
        check("R5 locked read zero", d, 32'h0);
    endtask

    task automatic t_ids();
        rd(12'hFC8, d, e, dl);
        check("R3 impl full", d, 32'h3);
        check("R3 impl lite", dl, 32'h2);
        rd(12'hFC4, d, e, dl);
        check("R3 offset none", d, 32'h1);
        check("R3 offset lite", dl, 32'h0);
    endtask

    task automatic t_unlock_reset_shadow();
        wr(12'h300, 32'h0);
        rd(12'h300, d, e, dl);
        check("R4 lock reads zero", d, 32'h0);
        rd(12'h0A4, d, e, dl);
        check("R8 reset shadow zero", d, 32'h0);
        check("R4 unlocked no error", {31'b0, e}, 32'h0);
    endtask

    task automatic t_capture(input logic [63:0] pc, input logic [31:0] ctx, input logic [3:0] fl,
                             input logic [7:0] vm);
        logic [31:0] exp_v;
        core_pc = pc; core_ctxid = ctx; {core_ns, core_el2, core_el3, core_aa64} = fl;
        core_vmid = vm;
        exp_v = {fl, 20'h0, vm};
        rd(12'h0A0, d, e, dl);
        check("R6 pc low", d, pc[31:0]);
        core_pc = ~pc; core_ctxid = ~ctx; core_vmid = ~vm;
        {core_ns, core_el2, core_el3, core_aa64} = ~fl;
        rd(12'h0A4, d, e, dl);
        check("R8 ctx shadow held", d, ctx);
        check("R11 lite ctx", dl, ctx);
        rd(12'h0A8, d, e, dl);
        check("R9 vctx layout", d, exp_v);
        check("R11 lite vctx zero", dl, 32'h0);
        rd(12'h0AC, d, e, dl);
        check("R6 pc high", d, pc[63:32]);
    endtask

    task automatic t_prohibit();
        logic [31:0] held;
        rd(12'h0A4, held, e, dl);
        core_halted = 1;
        rd(12'h0A0, d, e, dl);
        check("R7 halted ones", d, 32'hFFFF_FFFF);
        core_halted = 0; core_prof_off = 1; core_ctxid = 32'h1111_2222;
        rd(12'h0A0, d, e, dl);
        check("R7 prohibit ones", d, 32'hFFFF_FFFF);
        core_prof_off = 0;
        rd(12'h0A4, d, e, dl);
        check("R7 shadow unchanged", d, held);
    endtask

    task automatic t_readonly();
        logic [31:0] held;
        rd(12'h0A4, held, e, dl);
        wr(12'h0A4, 32'hDEAD_BEEF);
        rd(12'h0A4, d, e, dl);
        check("R10 ro write ignored", d, held);
        wr(12'h314, 32'hFFFF_FFFF);
        rd(12'h314, d, e, dl);
        check("R10 status unchanged", d, 32'h1);
        rd(12'h100, d, e, dl);
        check("R10 undefined zero", d, 32'h0);
        check("R10 undefined no err", {31'b0, e}, 32'h0);
    endtask

    task automatic t_gating();
        core_dbl_lock = 1;
        rd(12'h314, d, e, dl);
        check("R2 status dbl lock", d, 32'h41);
        rd(12'h0A0, d, e, dl);
        check("R5 dbl lock err", {31'b0, e}, 32'h1);
        wr(12'h300, 32'h1);
        core_dbl_lock = 0;
        rd(12'h0A0, d, e, dl);
        check("R4 lock write ignored", {31'b0, e}, 32'h0);
        wr(12'h300, 32'h5);
        rd(12'h0AC, d, e, dl);
        check("R4 relock err", {31'b0, e}, 32'h1);
        check("R5 relock zero", d, 32'h0);
        wr(12'h300, 32'h0);
        core_pwr_up = 0;
        rd(12'h0A0, d, e, dl);
        check("R5 power down err", {31'b0, e}, 32'h1);
        core_pwr_up = 1;
        rd(12'h0A0, d, e, dl);
        check("R4 power loss relocks", {31'b0, e}, 32'h1);
        rd(12'h314, d, e, dl);
        check("R2 status after power", d, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1;
        t_reset_idle();
        t_ids();
        t_unlock_reset_shadow();
        t_capture(64'h1234_5678_9ABC_DEF0, 32'hCAFE_0001, 4'b1101, 8'h5A);
        t_capture(64'h0000_00FF_0000_0040, 32'h0000_7777, 4'b0010, 8'hFF);
        t_prohibit();
        t_readonly();
        t_gating();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge pclk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule